// File: doc/BRIEF.md
# Configuration Access Port Translator

This block sits in a host bridge and turns processor I/O accesses to an indirect pair of 32-bit ports into bus configuration transactions. One port holds a 32-bit target address register: an enable flag plus bus, device, function and dword selectors. The other port is a window through which the processor reads or writes the selected configuration dword. The processor side offers a dword-granular I/O address, byte enables and a one-cycle request strobe, and gets a one-cycle acknowledge back with read data.

On a data-port access with the enable flag set, the block compares the target bus with the bridge's own bus number and its downstream (subordinate) bus number. A target on the bridge's own bus produces a local address phase: the device number is decoded into one of `NUM_SLOTS` one-hot select lines, and only the function and dword appear on the address word. A target on a bus behind the bridge produces a forwarded address phase that carries all four selector fields. Any other target, and any data-port access with the enable flag clear or any foreign port address, produces no configuration cycle. The block drives the address-phase word, command code, byte enables and select lines. It holds them until the bus side reports completion, and it substitutes all ones for the read data when no device claimed the cycle.

Top module: `cfg_port_xlate`

## Requirements
- R1: The address register is at dword address 14'h33E (byte 0CF8h). A write updates only the byte lanes whose `io_be` bit is set, a read returns the register, and either access is acknowledged with `io_ack` one cycle after acceptance; every write acknowledge returns `io_rdata` = 0.
- R2: Register layout: enable = bit 31, bus = bits 23:16, device = bits 15:11, function = bits 10:8, dword = bits 7:2; bits 30:24 and 1:0 always read as zero.
- R3: A data-port access (dword address 14'h33F, byte 0CFCh) with enable set, bus equal to `own_bus` and device below `NUM_SLOTS` raises `bus_start` one cycle after acceptance with `bus_ad` = {21'b0, function, dword, 2'b00}.
- R4: `bus_start` lasts exactly one cycle; `bus_active` then stays high and `bus_ad`, `bus_cmd`, `bus_be` and `bus_idsel` hold steady until `bus_done` is sampled high.
- R5: On a local cycle exactly one `bus_idsel` bit is set, at the index equal to the device number; on a forwarded cycle `bus_idsel` is all zero.
- R6: When `own_bus` < bus <= `sub_bus`, the cycle is forwarded with `bus_ad` = {8'b0, bus, device, function, dword, 2'b01}.
- R7: `bus_cmd` is 4'b1010 for a configuration read and 4'b1011 for a configuration write; `bus_be` equals the `io_be` of the data-port access.
- R8: `io_ack` rises one cycle after `bus_done` is sampled; for a read it returns `bus_rdata` if `bus_claimed` was high and 32'hFFFFFFFF otherwise.
- R9: A data-port access with enable clear, or an access to any other dword address, pulses `io_pass` one cycle after acceptance and produces neither `io_ack` nor `bus_start`.
- R10: With enable set but bus below `own_bus`, above `sub_bus`, or a local device number at or above `NUM_SLOTS`, no bus cycle starts; `io_ack` follows one cycle after acceptance, a read returning 32'hFFFFFFFF and a write being discarded.
- R11: `io_ready` is high when idle and low for the whole time a bus cycle is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Processor I/O request strobe, accepted when `io_ready` |
| io_we | input | 1 | 1 = write, 0 = read |
| io_dwaddr | input | 14 | Dword I/O address (byte address bits 15:2) |
| io_be | input | 4 | Byte enables of the access |
| io_wdata | input | 32 | Write data |
| io_ready | output | 1 | Block can accept a request |
| io_ack | output | 1 | One-cycle completion of an address- or data-port access |
| io_rdata | output | 32 | Read data, valid with `io_ack` |
| io_pass | output | 1 | One-cycle marker: access left to ordinary I/O decoding |
| own_bus | input | 8 | Bus number of the bridge's local bus |
| sub_bus | input | 8 | Highest bus number reachable behind the bridge |
| bus_start | output | 1 | First cycle of a configuration address phase |
| bus_active | output | 1 | Configuration cycle in progress |
| bus_ad | output | 32 | Address-phase word |
| bus_cmd | output | 4 | Configuration command code |
| bus_be | output | 4 | Byte enables for the data phase |
| bus_idsel | output | NUM_SLOTS | One-hot device select for local cycles |
| bus_done | input | 1 | Bus side reports the cycle finished |
| bus_claimed | input | 1 | A target claimed the cycle (valid with `bus_done`) |
| bus_rdata | input | 32 | Read data from the bus (valid with `bus_done`) |

## Verification
The hardest cases to reach are the edges of the routing decision: a bus number equal to the subordinate bound, one just below the own bus, one just above the subordinate bound, and a local device number just past the last select line. Each of these needs a specific address-register value loaded first and then a data-port access. The stimulus therefore programs the register through its port with exactly those boundary values, and in some cases with partial byte enables. For started cycles, a bus responder holds completion back for several cycles, so the held address phase and the deasserted ready can be observed before the acknowledge.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BE_W    = DATA_W / 8;
  localparam int unsigned DWA_W   = 14;

  localparam logic [DWA_W-1:0] ADDR_PORT_DW = 14'h33E;
  localparam logic [DWA_W-1:0] DATA_PORT_DW = 14'h33F;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  // bits that the address register keeps; all others read as zero
  localparam logic [DATA_W-1:0] ADDR_KEEP_MASK = 32'h80FF_FFFC;
  localparam logic [DATA_W-1:0] ALL_ONES       = '1;

  typedef enum logic [1:0] {RT_NONE, RT_LOCAL, RT_FWD} route_e;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_tgt_t;

  function automatic cfg_tgt_t unpack_tgt(input logic [DATA_W-1:0] r);
    cfg_tgt_t t;
    t.bus = r[23:16];
    t.dev = r[15:11];
    t.fn  = r[10:8];
    t.dw  = r[7:2];
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_v,
                                                    input logic [DATA_W-1:0] new_v,
                                                    input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int i = 0; i < BE_W; i++) begin
      if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
    end
    return r;
  endfunction

  function automatic route_e pick_route(input cfg_tgt_t t, input logic [7:0] own,
                                        input logic [7:0] sub, input int unsigned slots);
    if (t.bus == own) begin
      if (32'(t.dev) < slots) return RT_LOCAL;
      return RT_NONE;
    end
    if (t.bus > own && t.bus <= sub) return RT_FWD;
    return RT_NONE;
  endfunction

  function automatic logic [DATA_W-1:0] local_ad(input cfg_tgt_t t);
    return {21'd0, t.fn, t.dw, 2'b00};
  endfunction

  function automatic logic [DATA_W-1:0] fwd_ad(input cfg_tgt_t t);
    return {8'd0, t.bus, t.dev, t.fn, t.dw, 2'b01};
  endfunction

endpackage

// File: rtl/cfgx_addr_reg.sv
module cfgx_addr_reg
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_en) begin
      addr_q <= merge_bytes(addr_q, wr_data, wr_be) & ADDR_KEEP_MASK;
    end
  end

  // R1: the register changes only on an address-port write
  a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(addr_q));

endmodule

// File: rtl/cfgx_route.sv
module cfgx_route
  import cfgx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 21
) (
  input  cfg_tgt_t               tgt,
  input  logic [7:0]             own_bus,
  input  logic [7:0]             sub_bus,
  input  logic                   is_read,
  output route_e                 route,
  output logic [DATA_W-1:0]      ad_next,
  output logic [3:0]             cmd_next,
  output logic [NUM_SLOTS-1:0]   idsel_next
);

  always_comb begin
    route    = pick_route(tgt, own_bus, sub_bus, NUM_SLOTS);
    cmd_next = is_read ? CMD_CFG_RD : CMD_CFG_WR;
    case (route)
      RT_LOCAL: ad_next = local_ad(tgt);
      RT_FWD:   ad_next = fwd_ad(tgt);
      default:  ad_next = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_idsel
    assign idsel_next[g] = (route == RT_LOCAL) && (tgt.dev == 5'(g));
  end

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_req,
  input  logic                  io_we,
  input  logic [DWA_W-1:0]      io_dwaddr,
  input  logic [BE_W-1:0]       io_be,
  input  logic [DATA_W-1:0]     addr_q,
  input  route_e                route,
  input  logic [DATA_W-1:0]     ad_next,
  input  logic [3:0]            cmd_next,
  input  logic [NUM_SLOTS-1:0]  idsel_next,
  input  logic                  bus_done,
  input  logic                  bus_claimed,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic                  addr_wr,
  output logic                  io_ready,
  output logic                  io_ack,
  output logic [DATA_W-1:0]     io_rdata,
  output logic                  io_pass,
  output logic                  bus_start,
  output logic                  bus_active,
  output logic [DATA_W-1:0]     bus_ad,
  output logic [3:0]            bus_cmd,
  output logic [BE_W-1:0]       bus_be,
  output logic [NUM_SLOTS-1:0]  bus_idsel
);

  typedef enum logic {ST_IDLE, ST_BUS} state_e;
  state_e state;
  logic   rd_q;

  logic accept, hit_addr, hit_data, cfg_on;

  assign io_ready   = (state == ST_IDLE);
  assign bus_active = (state == ST_BUS);
  assign accept     = io_req && io_ready;
  assign hit_addr   = (io_dwaddr == ADDR_PORT_DW);
  assign hit_data   = (io_dwaddr == DATA_PORT_DW);
  assign cfg_on     = addr_q[31];
  assign addr_wr    = accept && io_we && hit_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rd_q      <= 1'b0;
      io_ack    <= 1'b0;
      io_rdata  <= '0;
      io_pass   <= 1'b0;
      bus_start <= 1'b0;
      bus_ad    <= '0;
      bus_cmd   <= '0;
      bus_be    <= '0;
      bus_idsel <= '0;
    end else begin
      io_ack    <= 1'b0;
      io_pass   <= 1'b0;
      bus_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (hit_addr) begin
              io_ack   <= 1'b1;
              io_rdata <= io_we ? '0 : addr_q;
            end else if (hit_data && cfg_on) begin
              if (route == RT_NONE) begin
                io_ack   <= 1'b1;
                io_rdata <= io_we ? '0 : ALL_ONES;
              end else begin
                state     <= ST_BUS;
                bus_start <= 1'b1;
                bus_ad    <= ad_next;
                bus_cmd   <= cmd_next;
                bus_be    <= io_be;
                bus_idsel <= idsel_next;
                rd_q      <= !io_we;
              end
            end else begin
              io_pass <= 1'b1;
            end
          end
        end
        ST_BUS: begin
          if (bus_done) begin
            state     <= ST_IDLE;
            io_ack    <= 1'b1;
            io_rdata  <= !rd_q ? '0 : (bus_claimed ? bus_rdata : ALL_ONES);
            bus_ad    <= '0;
            bus_cmd   <= '0;
            bus_be    <= '0;
            bus_idsel <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a start is always the first cycle of an active bus cycle
  a_r3_start_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> bus_active);

  // R4: start is a single-cycle pulse
  a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);

  // R4: address phase held until completion
  a_r4_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !bus_done) |=> ($stable(bus_ad) && $stable(bus_idsel) &&
                                   $stable(bus_cmd) && $stable(bus_be)));

  // R5: local cycle drives exactly one select line
  a_r5_local_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && bus_ad[1:0] == 2'b00) |-> ($countones(bus_idsel) == 1));

  // R5: forwarded cycle drives no select line
  a_r5_fwd_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && bus_ad[1:0] == 2'b01) |-> ($countones(bus_idsel) == 0));

  // R8: unclaimed read returns all ones
  a_r8_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && bus_done && !bus_claimed && bus_cmd == CMD_CFG_RD) |=>
      (io_ack && io_rdata == ALL_ONES));

  // R9: a passed-on access neither acknowledges nor starts a cycle
  a_r9_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    io_pass |-> (!io_ack && !bus_start && !bus_active));

endmodule

// File: rtl/cfg_port_xlate.sv
module cfg_port_xlate
  import cfgx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_req,
  input  logic                  io_we,
  input  logic [13:0]           io_dwaddr,
  input  logic [3:0]            io_be,
  input  logic [31:0]           io_wdata,
  output logic                  io_ready,
  output logic                  io_ack,
  output logic [31:0]           io_rdata,
  output logic                  io_pass,
  input  logic [7:0]            own_bus,
  input  logic [7:0]            sub_bus,
  output logic                  bus_start,
  output logic                  bus_active,
  output logic [31:0]           bus_ad,
  output logic [3:0]            bus_cmd,
  output logic [3:0]            bus_be,
  output logic [NUM_SLOTS-1:0]  bus_idsel,
  input  logic                  bus_done,
  input  logic                  bus_claimed,
  input  logic [31:0]           bus_rdata
);

  logic [DATA_W-1:0]     addr_q;
  logic                  addr_wr;
  cfg_tgt_t              tgt;
  route_e                route;
  logic [DATA_W-1:0]     ad_next;
  logic [3:0]            cmd_next;
  logic [NUM_SLOTS-1:0]  idsel_next;

  assign tgt = unpack_tgt(addr_q);

  cfgx_addr_reg u_areg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (addr_wr),
    .wr_be   (io_be),
    .wr_data (io_wdata),
    .addr_q  (addr_q)
  );

  cfgx_route #(.NUM_SLOTS(NUM_SLOTS)) u_route (
    .tgt        (tgt),
    .own_bus    (own_bus),
    .sub_bus    (sub_bus),
    .is_read    (!io_we),
    .route      (route),
    .ad_next    (ad_next),
    .cmd_next   (cmd_next),
    .idsel_next (idsel_next)
  );

  cfgx_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_req      (io_req),
    .io_we       (io_we),
    .io_dwaddr   (io_dwaddr),
    .io_be       (io_be),
    .addr_q      (addr_q),
    .route       (route),
    .ad_next     (ad_next),
    .cmd_next    (cmd_next),
    .idsel_next  (idsel_next),
    .bus_done    (bus_done),
    .bus_claimed (bus_claimed),
    .bus_rdata   (bus_rdata),
    .addr_wr     (addr_wr),
    .io_ready    (io_ready),
    .io_ack      (io_ack),
    .io_rdata    (io_rdata),
    .io_pass     (io_pass),
    .bus_start   (bus_start),
    .bus_active  (bus_active),
    .bus_ad      (bus_ad),
    .bus_cmd     (bus_cmd),
    .bus_be      (bus_be),
    .bus_idsel   (bus_idsel)
  );

endmodule

// File: tb/test_cfg_port_xlate.sv
`timescale 1ns/1ps
module test_cfg_port_xlate;

  localparam int SLOTS = 21;
  localparam logic [13:0] P_ADDR  = 14'h33E;
  localparam logic [13:0] P_DATA  = 14'h33F;
  localparam logic [13:0] P_OTHER = 14'h0018;
  localparam int K_START = 0, K_ACK = 1, K_PASS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_req = 0, io_we = 0;
  logic [13:0] io_dwaddr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic io_ready, io_ack, io_pass;
  logic [31:0] io_rdata;
  logic [7:0] own_bus = 8'd2, sub_bus = 8'd5;
  logic bus_start, bus_active;
  logic [31:0] bus_ad;
  logic [3:0] bus_cmd, bus_be;
  logic [SLOTS-1:0] bus_idsel;
  logic bus_done = 0, bus_claimed = 0;
  logic [31:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  cfg_port_xlate #(.NUM_SLOTS(SLOTS)) i_cfg_port_xlate (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_dwaddr(io_dwaddr),
    .io_be(io_be), .io_wdata(io_wdata), .io_ready(io_ready), .io_ack(io_ack),
    .io_rdata(io_rdata), .io_pass(io_pass), .own_bus(own_bus), .sub_bus(sub_bus),
    .bus_start(bus_start), .bus_active(bus_active), .bus_ad(bus_ad), .bus_cmd(bus_cmd),
    .bus_be(bus_be), .bus_idsel(bus_idsel), .bus_done(bus_done),
    .bus_claimed(bus_claimed), .bus_rdata(bus_rdata)
  );

  typedef struct {
    int          kind;
    logic [31:0] ad;
    logic [3:0]  cmd;
    logic [31:0] sel;
    logic [3:0]  be;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  wire [31:0] sel_w = {{(32-SLOTS){1'b0}}, bus_idsel};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expectation builders
  function automatic logic [31:0] mk_addr(input bit en, input int bus, input int dev,
                                          input int fn, input int dw);
    return (32'(en) << 31) | (32'(bus & 255) << 16) | (32'(dev & 31) << 11) |
           (32'(fn & 7) << 8) | (32'(dw & 63) << 2);
  endfunction
  function automatic logic [31:0] exp_local(input int fn, input int dw);
    return (32'(fn) * 256) + (32'(dw) * 4);
  endfunction
  function automatic logic [31:0] exp_fwd(input int bus, input int dev, input int fn, input int dw);
    return (32'(bus) * 65536) + (32'(dev) * 2048) + (32'(fn) * 256) + (32'(dw) * 4) + 32'd1;
  endfunction

  task automatic push_start(input logic [31:0] ad, input logic [3:0] cmd,
                            input logic [31:0] sel, input logic [3:0] be, input string tag);
    exp_t x;
    x.kind = K_START; x.ad = ad; x.cmd = cmd; x.sel = sel; x.be = be; x.data = '0; x.tag = tag;
    q.push_back(x);
  endtask
  task automatic push_ack(input logic [31:0] d, input string tag);
    exp_t x;
    x.kind = K_ACK; x.ad = '0; x.cmd = '0; x.sel = '0; x.be = '0; x.data = d; x.tag = tag;
    q.push_back(x);
  endtask
  task automatic push_pass(input string tag);
    exp_t x;
    x.kind = K_PASS; x.ad = '0; x.cmd = '0; x.sel = '0; x.be = '0; x.data = '0; x.tag = tag;
    q.push_back(x);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (bus_start) begin
        if (q.size() == 0) chk(0, "R9", "unexpected bus_start", 32'd1, 32'd0);
        else begin
          e = q.pop_front();
          chk(e.kind == K_START, e.tag, "event is bus_start", 32'(K_START), 32'(e.kind));
          if (e.kind == K_START) begin
            chk(bus_ad == e.ad, e.tag, "bus_ad", bus_ad, e.ad);
            chk(bus_cmd == e.cmd, "R7", "bus_cmd", 32'(bus_cmd), 32'(e.cmd));
            chk(bus_be == e.be, "R7", "bus_be", 32'(bus_be), 32'(e.be));
            chk(sel_w == e.sel, "R5", "bus_idsel", sel_w, e.sel);
          end
        end
      end
      if (io_ack) begin
        if (q.size() == 0) chk(0, "R9", "unexpected io_ack", 32'd1, 32'd0);
        else begin
          e = q.pop_front();
          chk(e.kind == K_ACK, e.tag, "event is io_ack", 32'(K_ACK), 32'(e.kind));
          if (e.kind == K_ACK) chk(io_rdata == e.data, e.tag, "io_rdata", io_rdata, e.data);
        end
      end
      if (io_pass) begin
        if (q.size() == 0) chk(0, "R9", "unexpected io_pass", 32'd1, 32'd0);
        else begin
          e = q.pop_front();
          chk(e.kind == K_PASS, e.tag, "event is io_pass", 32'(K_PASS), 32'(e.kind));
        end
      end
    end
  end

  // driver
  task automatic io_op(input logic we, input logic [13:0] dwa, input logic [3:0] be,
                       input logic [31:0] wd);
    @(posedge clk); #1;
    io_req = 1; io_we = we; io_dwaddr = dwa; io_be = be; io_wdata = wd;
    @(posedge clk); #1;
    io_req = 0; io_we = 0; io_be = '0; io_wdata = '0;
  endtask

  task automatic bus_reply(input bit claimed, input logic [31:0] rd, input int hold,
                           input logic [31:0] ad_exp);
    while (!bus_active) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(bus_active && !io_ready, "R11", "busy while cycle active",
          32'({bus_active, io_ready}), 32'b10);
      chk(bus_ad == ad_exp, "R4", "address phase held", bus_ad, ad_exp);
    end
    @(posedge clk); #1;
    bus_done = 1; bus_claimed = claimed; bus_rdata = rd;
    @(posedge clk); #1;
    bus_done = 0; bus_claimed = 0; bus_rdata = '0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic set_addr(input logic [31:0] a);
    push_ack(32'd0, "R1");
    io_op(1, P_ADDR, 4'hF, a);
    settle();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(io_ready == 1'b1, "R11", "ready after reset", 32'(io_ready), 32'd1);
    chk(!bus_active && !bus_start && !io_ack, "R4", "quiet after reset",
        32'({bus_active, bus_start, io_ack}), 32'd0);

    // R1: reset value readback
    push_ack(32'd0, "R1"); io_op(0, P_ADDR, 4'hF, '0); settle();

    // R2: reserved bits read zero
    set_addr(32'hFFFF_FFFF);
    push_ack(32'h80FF_FFFC, "R2"); io_op(0, P_ADDR, 4'hF, '0); settle();

    // R1: byte-lane update
    set_addr(32'h0);
    push_ack(32'd0, "R1"); io_op(1, P_ADDR, 4'b0100, 32'hDDAB_CCEE); settle();
    push_ack(32'h00AB_0000, "R1"); io_op(0, P_ADDR, 4'hF, '0); settle();

    // R3 local read, claimed
    set_addr(mk_addr(1, 2, 3, 5, 63));
    push_start(exp_local(5, 63), 4'b1010, 32'd1 << 3, 4'b0011, "R3");
    push_ack(32'h1234_5678, "R8");
    io_op(0, P_DATA, 4'b0011, '0);
    bus_reply(1, 32'h1234_5678, 3, exp_local(5, 63)); settle();

    // R8 local read, last slot, unclaimed
    set_addr(mk_addr(1, 2, SLOTS-1, 0, 1));
    push_start(exp_local(0, 1), 4'b1010, 32'd1 << (SLOTS-1), 4'hF, "R3");
    push_ack(32'hFFFF_FFFF, "R8");
    io_op(0, P_DATA, 4'hF, '0);
    bus_reply(0, 32'h5555_AAAA, 1, exp_local(0, 1)); settle();

    // R7 local write, device 0
    set_addr(mk_addr(1, 2, 0, 7, 16));
    push_start(exp_local(7, 16), 4'b1011, 32'd1, 4'b1000, "R7");
    push_ack(32'd0, "R7");
    io_op(1, P_DATA, 4'b1000, 32'hCAFE_0000);
    bus_reply(1, 32'h9999_9999, 0, exp_local(7, 16)); settle();

    // R6 forwarded read at upper bound
    set_addr(mk_addr(1, 5, 31, 2, 9));
    push_start(exp_fwd(5, 31, 2, 9), 4'b1010, 32'd0, 4'hF, "R6");
    push_ack(32'hA5A5_0F0F, "R8");
    io_op(0, P_DATA, 4'hF, '0);
    bus_reply(1, 32'hA5A5_0F0F, 2, exp_fwd(5, 31, 2, 9)); settle();

    // R6 forwarded write just above own bus
    set_addr(mk_addr(1, 3, 12, 1, 40));
    push_start(exp_fwd(3, 12, 1, 40), 4'b1011, 32'd0, 4'b0110, "R6");
    push_ack(32'd0, "R7");
    io_op(1, P_DATA, 4'b0110, 32'h0BAD_F00D);
    bus_reply(0, '0, 1, exp_fwd(3, 12, 1, 40)); settle();

    // R10 out of range targets
    set_addr(mk_addr(1, 6, 1, 0, 0));
    push_ack(32'hFFFF_FFFF, "R10"); io_op(0, P_DATA, 4'hF, '0); settle();
    set_addr(mk_addr(1, 1, 1, 0, 0));
    push_ack(32'hFFFF_FFFF, "R10"); io_op(0, P_DATA, 4'hF, '0); settle();
    set_addr(mk_addr(1, 2, SLOTS, 0, 0));
    push_ack(32'hFFFF_FFFF, "R10"); io_op(0, P_DATA, 4'hF, '0); settle();
    push_ack(32'd0, "R10"); io_op(1, P_DATA, 4'hF, 32'h1111_2222); settle();
    // register unchanged by the discarded write
    push_ack(mk_addr(1, 2, SLOTS, 0, 0), "R10"); io_op(0, P_ADDR, 4'hF, '0); settle();

    // R9 enable clear and foreign port
    set_addr(mk_addr(0, 2, 3, 0, 0));
    push_pass("R9"); io_op(0, P_DATA, 4'hF, '0); settle();
    push_pass("R9"); io_op(1, P_DATA, 4'hF, 32'h7777_7777); settle();
    push_pass("R9"); io_op(0, P_OTHER, 4'hF, '0); settle();
    push_ack(mk_addr(0, 2, 3, 0, 0), "R9"); io_op(0, P_ADDR, 4'hF, '0); settle();

    @(negedge clk);
    chk(q.size() == 0, "R9", "all expected events seen", 32'(q.size()), 32'd0);
    chk(io_ready == 1'b1, "R11", "ready when idle", 32'(io_ready), 32'd1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule